// File: doc/BRIEF.md
# Pipelined SPI ADC Stand-In

This block is a synthesizable SPI slave that acts in place of a multi-channel sampling ADC. A master sends 16-bit command words, each framed by a low period of chip select. A command with its write-enable bit set picks the channel to sample, the operating mode and the input range. The sample values come from a parallel bus of per-channel registers instead of analog pins, so firmware and SPI masters can be exercised against a known data source.

The response is pipelined. The channel chosen by a frame is captured when that frame ends. The following frame stands for the conversion time. The result is shifted out during the frame after that, so each reply arrives two frames after the command that asked for it. Every reply word carries the 4-bit number of its channel above a left-aligned sample of 8, 10 or 12 bits. The number of channels (4, 8, 12 or 16) and the result width are parameters.

SPI inputs are resynchronised to the system clock. The bus uses clock polarity 0 and phase 0: the master changes data on the falling SPI clock and samples it on the rising SPI clock.

Top module: `adc_spi_emu`

## Requirements
- R1: A frame is the span between a falling and a rising edge of `spi_cs_n`. The slave shifts `spi_mosi` in on each rising `spi_sclk`, MSB first. The last 16 bits received before chip select rises form the command word.
- R2: A command with bit 11 = 1 loads new settings. The channel comes from bits 10:7, manual mode from bit 12 and the doubled range from bit 6. The loaded values appear on `cfg_chan`, `cfg_manual` and `cfg_range_x2`. Settings change only at the end of a frame.
- R3: A command with bit 11 = 0 leaves all settings unchanged, and it still advances the response pipeline by one frame.
- R4: The reply shifted out during frame N+2 belongs to the channel that was in effect when frame N ended.
- R5: A reply word holds the channel number in bits 15:12 and the sample in bits 11 down to 12-RES_BITS. The bits below the sample are zero.
- R6: After reset all settings are zero, and the replies in the first two frames are all zeros.
- R7: A channel number at or above NUM_CH returns a word with zero sample bits. Bits 15:12 still hold the requested channel number.
- R8: `spi_miso` is 0 while chip select is high. The first reply bit is valid before the first rising `spi_sclk` of a frame, and each later bit changes after a falling `spi_sclk`.
- R9: The sample is taken from `sample_bus` at the end of the selecting frame. Changes to `sample_bus` after that point do not alter the reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select; a rising edge ends a frame |
| spi_mosi | input | 1 | Serial command data from the master |
| spi_miso | output | 1 | Serial reply data, MSB first, 0 while deselected |
| sample_bus | input | NUM_CH*RES_BITS | Per-channel sample values; channel k is in bits k*RES_BITS upward |
| cfg_manual | output | 1 | Stored manual-mode setting |
| cfg_range_x2 | output | 1 | Stored doubled-range setting |
| cfg_chan | output | 4 | Stored channel selection |

## Verification
There are two timescales. Settings appear on the `cfg_*` outputs a few system clocks after chip select rises: the resynchroniser, the edge detector and the settings register each add one clock. The bench checks them only after an idle gap of twelve clocks. Each reply is due exactly two frames after its command, so the bench model keeps a two-entry pipeline that it shifts once per frame and compares against the word it shifts in during that frame. Sample values are redrawn at the start of every frame, after the previous capture has completed, so any late capture shows up as a mismatch.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  localparam int WORD_W  = 16;
  localparam int CHID_W  = 4;
  localparam int FULL_W  = 12;
  // command field positions decoded by the settings stage
  localparam int BIT_WREN  = 11;
  localparam int BIT_MAN   = 12;
  localparam int BIT_RANGE = 6;
  localparam int CHAN_LSB  = 7;

  typedef struct packed {
    logic              manual;
    logic              range_x2;
    logic [CHID_W-1:0] chan;
  } emu_cfg_t;
endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import adc_emu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [WORD_W-1:0] tx_word,
  output logic              frame_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              miso,
  output logic              cs_idle
);
  logic [SYNC_STAGES-1:0] sclk_sy, cs_sy, mosi_sy;
  logic sclk_d, cs_d;
  logic [WORD_W-1:0] rx_sr, tx_sr;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall;

  assign sclk_rise = sclk_sy[SYNC_STAGES-1] & ~sclk_d;
  assign sclk_fall = ~sclk_sy[SYNC_STAGES-1] & sclk_d;
  assign cs_rise   = cs_sy[SYNC_STAGES-1] & ~cs_d;
  assign cs_fall   = ~cs_sy[SYNC_STAGES-1] & cs_d;
  assign cs_idle   = cs_sy[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sy    <= '0;
      cs_sy      <= '1;
      mosi_sy    <= '0;
      sclk_d     <= 1'b0;
      cs_d       <= 1'b1;
      rx_sr      <= '0;
      tx_sr      <= '0;
      rx_word    <= '0;
      frame_done <= 1'b0;
      miso       <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk};
      cs_sy   <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi};
      sclk_d  <= sclk_sy[SYNC_STAGES-1];
      cs_d    <= cs_sy[SYNC_STAGES-1];
      if (cs_fall) begin
        tx_sr <= tx_word;
      end else if (!cs_idle && sclk_rise) begin
        rx_sr <= {rx_sr[WORD_W-2:0], mosi_sy[SYNC_STAGES-1]};
      end else if (!cs_idle && sclk_fall) begin
        tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
      end
      frame_done <= cs_rise;
      if (cs_rise) rx_word <= rx_sr;
      miso <= cs_idle ? 1'b0 : tx_sr[WORD_W-1];
    end
  end
endmodule

// File: rtl/cfg_decode.sv
module cfg_decode
  import adc_emu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] rx_word,
  output emu_cfg_t          cfg,
  output logic              upd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
      upd <= 1'b0;
    end else begin
      upd <= frame_done;
      if (frame_done && rx_word[BIT_WREN]) begin
        cfg.manual   <= rx_word[BIT_MAN];
        cfg.range_x2 <= rx_word[BIT_RANGE];
        cfg.chan     <= rx_word[CHAN_LSB +: CHID_W];
      end
    end
  end
endmodule

// File: rtl/sample_pipe.sv
module sample_pipe
  import adc_emu_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       upd,
  input  logic [CHID_W-1:0]          chan,
  input  logic [NUM_CH*RES_BITS-1:0] sample_bus,
  output logic [WORD_W-1:0]          conv_word,
  output logic [WORD_W-1:0]          tx_word
);
  localparam int MSB_POS = FULL_W - 1;

  logic [RES_BITS-1:0] picked;
  logic [WORD_W-1:0]   fresh;
  int unsigned         sel;
  logic                in_range;

  always_comb begin
    in_range = (int'(chan) < NUM_CH);
    sel      = in_range ? int'(chan) : 0;
    picked   = in_range ? sample_bus[sel*RES_BITS +: RES_BITS] : '0;
    fresh    = '0;
    fresh[WORD_W-1 -: CHID_W]  = chan;
    fresh[MSB_POS -: RES_BITS] = picked;
  end

  // two stages: capture (conversion frame) then shift-out frame
  always_ff @(posedge clk) begin
    if (rst) begin
      conv_word <= '0;
      tx_word   <= '0;
    end else if (upd) begin
      tx_word   <= conv_word;
      conv_word <= fresh;
    end
  end
endmodule

// File: rtl/adc_spi_emu.sv
module adc_spi_emu
  import adc_emu_pkg::*;
#(
  parameter int NUM_CH      = 16,
  parameter int RES_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       spi_sclk,
  input  logic                       spi_cs_n,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  input  logic [NUM_CH*RES_BITS-1:0] sample_bus,
  output logic                       cfg_manual,
  output logic                       cfg_range_x2,
  output logic [CHID_W-1:0]          cfg_chan
);
  logic              frame_done, cs_idle, cfg_upd;
  logic [WORD_W-1:0] rx_word, tx_word, conv_word;
  emu_cfg_t          cfg;

  spi_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .tx_word(tx_word), .frame_done(frame_done), .rx_word(rx_word),
    .miso(spi_miso), .cs_idle(cs_idle)
  );

  cfg_decode u_cfg (
    .clk(clk), .rst(rst), .frame_done(frame_done), .rx_word(rx_word),
    .cfg(cfg), .upd(cfg_upd)
  );

  sample_pipe #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_pipe (
    .clk(clk), .rst(rst), .upd(cfg_upd), .chan(cfg.chan),
    .sample_bus(sample_bus), .conv_word(conv_word), .tx_word(tx_word)
  );

  assign cfg_manual   = cfg.manual;
  assign cfg_range_x2 = cfg.range_x2;
  assign cfg_chan     = cfg.chan;
endmodule

// File: rtl/adc_emu_checker.sv
module adc_emu_checker #(
  parameter int NUM_CH   = 16,
  parameter int RES_BITS = 12
) (
  input logic        clk,
  input logic        rst,
  input logic        cs_idle,
  input logic        spi_miso,
  input logic        frame_done,
  input logic [15:0] rx_word,
  input logic        cfg_upd,
  input logic        cfg_manual,
  input logic        cfg_range_x2,
  input logic [3:0]  cfg_chan,
  input logic [15:0] conv_word,
  input logic [15:0] tx_word
);
  localparam logic [15:0] PAD_MASK = 16'((32'd1 << (12 - RES_BITS)) - 1);

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
    (cs_idle && $past(cs_idle)) |-> !spi_miso);

  assert_load_cfg_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_done && rx_word[11]) |=>
      (cfg_chan == $past(rx_word[10:7]) && cfg_manual == $past(rx_word[12])
       && cfg_range_x2 == $past(rx_word[6])));

  assert_cfg_only_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> ($stable(cfg_chan) && $stable(cfg_manual) && $stable(cfg_range_x2)));

  assert_hold_cfg_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !rx_word[11]) |=>
      ($stable(cfg_chan) && $stable(cfg_manual) && $stable(cfg_range_x2)));

  assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_upd |=> (tx_word == $past(conv_word)));

  assert_tag_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_upd |=> (conv_word[15:12] == cfg_chan));

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (conv_word & PAD_MASK) == 16'h0);

  assert_out_of_range_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_upd && int'(cfg_chan) >= NUM_CH) |=> (conv_word[11:0] == 12'h0));
endmodule

bind adc_spi_emu adc_emu_checker #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst(rst), .cs_idle(cs_idle), .spi_miso(spi_miso),
  .frame_done(frame_done), .rx_word(rx_word), .cfg_upd(cfg_upd),
  .cfg_manual(cfg_manual), .cfg_range_x2(cfg_range_x2), .cfg_chan(cfg_chan),
  .conv_word(conv_word), .tx_word(tx_word)
);

// File: tb/test_adc_spi_emu.sv
module test_adc_spi_emu;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 12;
  localparam int RES_BITS   = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [NUM_CH*RES_BITS-1:0] sample_bus = '0;
  logic cfg_manual, cfg_range_x2;
  logic [3:0] cfg_chan;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_chan;
  logic m_man, m_rng;
  logic [15:0] m_conv, m_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_spi_emu #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) i_adc_spi_emu (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .sample_bus(sample_bus),
    .cfg_manual(cfg_manual), .cfg_range_x2(cfg_range_x2), .cfg_chan(cfg_chan)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(input logic [3:0] ch, input logic [NUM_CH*RES_BITS-1:0] s);
    logic [15:0] w;
    w = '0;
    w[15:12] = ch;
    if (int'(ch) < NUM_CH) w[11 -: RES_BITS] = s[int'(ch)*RES_BITS +: RES_BITS];
    return w;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame as master; checks reply (R4, R5, R9) and settings (R1, R2, R3)
  task automatic frame(input logic [15:0] cmd);
    logic [15:0] rsp;
    logic [15:0] exp_rsp;
    exp_rsp = m_out;
    spi_cs_n = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < NUM_CH; k++) sample_bus[k*RES_BITS +: RES_BITS] = RES_BITS'($urandom);
    for (int i = 15; i >= 0; i--) begin
      spi_mosi = cmd[i];
      wait_clk(HALF);
      spi_sclk = 1'b1;
      rsp[i] = spi_miso;
      wait_clk(HALF);
      spi_sclk = 1'b0;
    end
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(12);
    check("R4 R5 R9 reply word", {16'h0, rsp}, {16'h0, exp_rsp});
    if (cmd[11]) begin
      m_chan = cmd[10:7];
      m_man  = cmd[12];
      m_rng  = cmd[6];
    end
    m_out  = m_conv;
    m_conv = fmt(m_chan, sample_bus);
    check(cmd[11] ? "R1 R2 settings load" : "R3 settings held",
          {25'h0, cfg_manual, cfg_range_x2, cfg_chan, 1'b0},
          {25'h0, m_man, m_rng, m_chan, 1'b0});
    check("R8 miso idle", {31'h0, spi_miso}, 32'h0);
  endtask

  function automatic logic [15:0] mk(input logic wr, input logic man, input logic rng, input logic [3:0] ch);
    logic [15:0] c;
    c = 16'($urandom);
    c[11] = wr; c[12] = man; c[6] = rng; c[10:7] = ch;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    m_chan = '0; m_man = 1'b0; m_rng = 1'b0; m_conv = '0; m_out = '0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    check("R6 reset settings", {27'h0, cfg_manual, cfg_range_x2, cfg_chan}, 32'h0);
    check("R6 reset miso", {31'h0, spi_miso}, 32'h0);
    // R6: first two replies are zero (model holds zeros)
    frame(mk(1'b1, 1'b1, 1'b0, 4'd3));
    frame(mk(1'b1, 1'b0, 1'b1, 4'd5));
    // R3: bit 11 clear keeps channel 5 and still shifts the pipeline
    frame(mk(1'b0, 1'b1, 1'b0, 4'd9));
    // R7: channels above the configured count
    frame(mk(1'b1, 1'b0, 1'b0, 4'd14));
    frame(mk(1'b1, 1'b1, 1'b1, 4'd12));
    frame(mk(1'b0, 1'b0, 1'b0, 4'd0));
    frame(mk(1'b1, 1'b0, 1'b0, 4'd11));
    frame(mk(1'b1, 1'b0, 1'b0, 4'd0));
    frame(mk(1'b1, 1'b0, 1'b0, 4'd15));
    // random mix
    for (int n = 0; n < 40; n++) frame(16'($urandom));
    frame(16'h0000);
    frame(16'h0000);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule